// File: doc/BRIEF.md
# Prefixed Bit-Manipulation Opcode Executor

This block carries out the second half of a two-byte instruction on an 8-bit processor: the shift, rotate, nibble swap, bit test, bit clear and bit set family that sits behind a prefix byte. The surrounding core presents the opcode it has just fetched, together with its program counter, on a start strobe. If that opcode is the prefix value, the block reads one more byte at the program counter, advances the counter by one, and decodes that byte. The decode gives an operation group, a bit index or sub-operation, and an operand selector.

The operand comes from one of seven byte registers or from memory at the address formed by the H (high) and L (low) registers. The register file and flag register stay outside the block. The block reads all register slots through one flat bus and the current carry through one pin. It commits results through one register write port and one flag write port, both pulsed in the completion cycle. Memory operands use a read, compute, write sequence on a byte-wide request port.

Completion is signalled by a one-cycle `done` pulse. It comes in cycle 8 after acceptance for a register operand and in cycle 16 for a memory operand. The memory request port is valid/ready. Once the block raises `mem_valid`, it holds the address, direction and write data steady until a cycle in which `mem_ready` is high, and the transfer takes place in that cycle. For a read, `mem_rdata` must be valid in that same cycle. Ready-low cycles that fit inside the cycle budget do not delay `done`. Longer stalls move `done` to the cycle after the last transfer.

Top module: `pfx_exec`

## Requirements
- R1: A start is accepted only when the block is idle and `first_op` equals 0xCB. A start with any other opcode leaves the block idle, with no memory request and no `done`.
- R2: After acceptance, the first memory transfer is a read at `pc_i`. At `done`, `pc_o` equals `pc_i` plus one.
- R3: Bits 2:0 of the fetched byte select the operand. Values 0, 1, 2, 3, 4, 5 and 7 select register slots B, C, D, E, H, L and A; `rf_wsel` carries the same code. Value 6 selects memory at address {H, L}, with H in slot 4 and L in slot 5. Slot 6 of `rf_rd` is never used.
- R4: When bits 7:6 are 00, bits 5:3 choose the operation:
  - 0: rotate left, old bit 7 into bit 0.
  - 1: rotate right, old bit 0 into bit 7.
  - 2: rotate left through carry.
  - 3: rotate right through carry.
  - 4: shift left, zero fill.
  - 5: shift right, keeping bit 7.
  - 6: swap nibbles.
  - 7: shift right, zero fill.

  The outgoing bit becomes C; C is 0 for swap. Z is set when the result is zero. N and H are cleared. The result and the flags are both written.
- R5: When bits 7:6 are 01, the flags are written with Z set if bit [5:3] of the operand is 0, N=0, H=1 and C equal to `carry_i`. Nothing is written to a register or to memory.
- R6: When bits 7:6 are 10, bit [5:3] of the operand is cleared. When they are 11, it is set. The result is written back, and the flags are not written.
- R7: With `mem_ready` held high, `done` comes in cycle 8 after the accepting edge for a register operand and in cycle 16 for a memory operand, in every group.
- R8: For a memory operand, the block reads {H, L} and, except in the bit-test group, writes the result back to that same address exactly once.
- R9: The flag byte holds Z at bit 7, N at bit 6, H at bit 5 and C at bit 4. Its lower nibble is always written as zero.
- R10: While `mem_valid` is high and `mem_ready` is low, the request fields stay stable. Stalls inside the budget leave `done` where R7 puts it. Otherwise `done` comes in the cycle after the last transfer.
- R11: `done` lasts exactly one cycle. `rf_we` and `flags_we` are asserted only in the `done` cycle.
- R12: A synchronous reset returns the block to idle, with `pc_o` at zero, from any state. A start that arrives while the block is busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start strobe with the first opcode |
| first_op | input | 8 | First opcode byte |
| pc_i | input | 16 | Address of the byte after the prefix |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_o | output | 16 | Advanced program counter |
| rf_rd | input | 64 | Register slots, slot i at bits 8i+7:8i |
| carry_i | input | 1 | Current carry flag |
| rf_we | output | 1 | Register write strobe |
| rf_wsel | output | 3 | Register slot written |
| rf_wdata | output | 8 | Register write data |
| flags_we | output | 1 | Flag write strobe |
| flags_wdata | output | 8 | New flag byte |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory request accepted |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 16 | Request address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid while ready is high |

## Verification
Faults in the decode show up as soon as `done` fires. A wrong group or sub-operation puts a wrong result byte on the register or memory write path, or wrong flags on the flag path. A wrong operand code either leaves the slot alone or pulls the operand from the wrong place, which also corrupts `mem_addr` on the read. A sequencing fault, such as a miscounted budget, a skipped write or a missed stall, moves the `done` pulse away from cycle 8 or 16, or changes the number of memory writes, so the first instruction that reaches it exposes it.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  localparam int BYTE_W = 8;
  localparam int SEL_W  = 3;
  localparam int NSLOT  = 1 << SEL_W;

  // operand codes with structural meaning
  localparam logic [SEL_W-1:0] SEL_MEM = 3'd6;
  localparam logic [SEL_W-1:0] SEL_HI  = 3'd4;
  localparam logic [SEL_W-1:0] SEL_LO  = 3'd5;

  // flag byte layout
  localparam int FLAG_Z = 7;
  localparam int FLAG_N = 6;
  localparam int FLAG_H = 5;
  localparam int FLAG_C = 4;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_TEST  = 2'd1,
    GRP_CLR   = 2'd2,
    GRP_SET   = 2'd3
  } grp_e;

  typedef enum logic [2:0] {
    SH_ROL  = 3'd0,
    SH_ROR  = 3'd1,
    SH_RCL  = 3'd2,
    SH_RCR  = 3'd3,
    SH_SHL  = 3'd4,
    SH_ASR  = 3'd5,
    SH_NIB  = 3'd6,
    SH_LSR  = 3'd7
  } shop_e;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_MRD   = 3'd2,
    ST_MWR   = 3'd3,
    ST_WAIT  = 3'd4
  } st_e;

  typedef struct packed {
    grp_e             grp;
    logic [2:0]       sub;
    logic [SEL_W-1:0] sel;
    logic             is_mem;
    logic             wr_rf;
    logic             wr_mem;
    logic             wr_flags;
  } dec_t;
endpackage

// File: rtl/pfx_decode.sv
module pfx_decode
  import pfx_pkg::*;
#(
  parameter int REG_CYCLES = 8,
  parameter int MEM_CYCLES = 16,
  parameter int CNT_W      = 6
) (
  input  logic [BYTE_W-1:0] op,
  output dec_t              dec,
  output logic [CNT_W-1:0]  budget
);
  grp_e grp;
  logic mem_sel;

  assign grp     = grp_e'(op[7:6]);
  assign mem_sel = (op[SEL_W-1:0] == SEL_MEM);

  always_comb begin
    dec.grp      = grp;
    dec.sub      = op[5:3];
    dec.sel      = op[SEL_W-1:0];
    dec.is_mem   = mem_sel;
    dec.wr_rf    = !mem_sel && (grp != GRP_TEST);
    dec.wr_mem   = mem_sel && (grp != GRP_TEST);
    dec.wr_flags = (grp == GRP_SHIFT) || (grp == GRP_TEST);
  end

  assign budget = mem_sel ? CNT_W'(MEM_CYCLES) : CNT_W'(REG_CYCLES);
endmodule

// File: rtl/pfx_bitunit.sv
module pfx_bitunit
  import pfx_pkg::*;
(
  input  grp_e              grp,
  input  logic [2:0]        sub,
  input  logic [BYTE_W-1:0] din,
  input  logic              cin,
  output logic [BYTE_W-1:0] dout,
  output logic [BYTE_W-1:0] fout
);
  logic [BYTE_W-1:0] mask;
  logic z, n, h, c;

  assign mask = BYTE_W'(1) << sub;

  always_comb begin
    dout = din;
    z = 1'b0;
    n = 1'b0;
    h = 1'b0;
    c = 1'b0;
    case (grp)
      GRP_SHIFT: begin
        case (shop_e'(sub))
          SH_ROL: begin dout = {din[6:0], din[7]}; c = din[7]; end
          SH_ROR: begin dout = {din[0], din[7:1]}; c = din[0]; end
          SH_RCL: begin dout = {din[6:0], cin};    c = din[7]; end
          SH_RCR: begin dout = {cin, din[7:1]};    c = din[0]; end
          SH_SHL: begin dout = {din[6:0], 1'b0};   c = din[7]; end
          SH_ASR: begin dout = {din[7], din[7:1]}; c = din[0]; end
          SH_NIB: begin dout = {din[3:0], din[7:4]}; c = 1'b0; end
          default: begin dout = {1'b0, din[7:1]}; c = din[0]; end
        endcase
        z = (dout == '0);
      end
      GRP_TEST: begin
        z = ~|(din & mask);
        h = 1'b1;
        c = cin;
      end
      GRP_CLR: dout = din & ~mask;
      default: dout = din | mask;
    endcase
  end

  always_comb begin
    fout = '0;
    fout[FLAG_Z] = z;
    fout[FLAG_N] = n;
    fout[FLAG_H] = h;
    fout[FLAG_C] = c;
  end
endmodule

// File: rtl/pfx_seq.sv
module pfx_seq
  import pfx_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  logic             xfer,
  input  logic             is_mem,
  input  logic             wr_mem,
  input  logic [CNT_W-1:0] budget,
  output st_e              state,
  output logic             done
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  st_e              st_q, st_d;
  logic [CNT_W-1:0] cnt_q;
  logic             spent;

  assign spent = (cnt_q >= budget);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_IDLE:  if (accept) st_d = ST_FETCH;
      ST_FETCH: if (xfer) st_d = is_mem ? ST_MRD : ST_WAIT;
      ST_MRD:   if (xfer) st_d = wr_mem ? ST_MWR : ST_WAIT;
      ST_MWR:   if (xfer) st_d = ST_WAIT;
      ST_WAIT:  if (spent) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE) begin
        cnt_q <= accept ? CNT_W'(1) : '0;
      end else if (cnt_q != CNT_MAX) begin
        cnt_q <= cnt_q + CNT_W'(1);
      end
    end
  end

  assign state = st_q;
  assign done  = (st_q == ST_WAIT) && spent;
endmodule

// File: rtl/pfx_exec.sv
module pfx_exec
  import pfx_pkg::*;
#(
  parameter logic [7:0] PREFIX     = 8'hCB,
  parameter int         REG_CYCLES = 8,
  parameter int         MEM_CYCLES = 16
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [BYTE_W-1:0]       first_op,
  input  logic [2*BYTE_W-1:0]     pc_i,
  output logic                    busy,
  output logic                    done,
  output logic [2*BYTE_W-1:0]     pc_o,
  input  logic [NSLOT*BYTE_W-1:0] rf_rd,
  input  logic                    carry_i,
  output logic                    rf_we,
  output logic [SEL_W-1:0]        rf_wsel,
  output logic [BYTE_W-1:0]       rf_wdata,
  output logic                    flags_we,
  output logic [BYTE_W-1:0]       flags_wdata,
  output logic                    mem_valid,
  input  logic                    mem_ready,
  output logic                    mem_we,
  output logic [2*BYTE_W-1:0]     mem_addr,
  output logic [BYTE_W-1:0]       mem_wdata,
  input  logic [BYTE_W-1:0]       mem_rdata
);
  localparam int ADDR_W = 2 * BYTE_W;
  localparam int CNT_W  = $clog2(MEM_CYCLES + 1) + 1;

  st_e               state;
  dec_t              dec;
  logic [CNT_W-1:0]  budget;
  logic              accept, xfer;
  logic [BYTE_W-1:0] op2_q, opnd_q, op_cur, operand, alu_out, alu_flags;
  logic [ADDR_W-1:0] pc_q;
  logic [BYTE_W-1:0] regv [NSLOT];

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign regv[g] = rf_rd[g*BYTE_W +: BYTE_W];
  end

  assign accept = start && (state == ST_IDLE) && (first_op == PREFIX);
  assign xfer   = mem_valid && mem_ready;
  assign op_cur = (state == ST_FETCH) ? mem_rdata : op2_q;

  pfx_decode #(
    .REG_CYCLES(REG_CYCLES),
    .MEM_CYCLES(MEM_CYCLES),
    .CNT_W     (CNT_W)
  ) u_dec (
    .op    (op_cur),
    .dec   (dec),
    .budget(budget)
  );

  pfx_seq #(.CNT_W(CNT_W)) u_seq (
    .clk   (clk),
    .rst   (rst),
    .accept(accept),
    .xfer  (xfer),
    .is_mem(dec.is_mem),
    .wr_mem(dec.wr_mem),
    .budget(budget),
    .state (state),
    .done  (done)
  );

  assign operand = dec.is_mem ? opnd_q : regv[dec.sel];

  pfx_bitunit u_alu (
    .grp (dec.grp),
    .sub (dec.sub),
    .din (operand),
    .cin (carry_i),
    .dout(alu_out),
    .fout(alu_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      op2_q  <= '0;
      opnd_q <= '0;
      pc_q   <= '0;
    end else begin
      if (accept) pc_q <= pc_i;
      if (state == ST_FETCH && xfer) begin
        op2_q <= mem_rdata;
        pc_q  <= pc_q + ADDR_W'(1);
      end
      if (state == ST_MRD && xfer) opnd_q <= mem_rdata;
    end
  end

  assign busy      = (state != ST_IDLE);
  assign pc_o      = pc_q;
  assign mem_valid = (state == ST_FETCH) || (state == ST_MRD) || (state == ST_MWR);
  assign mem_we    = (state == ST_MWR);
  assign mem_addr  = (state == ST_FETCH) ? pc_q : {regv[SEL_HI], regv[SEL_LO]};
  assign mem_wdata = (state == ST_MWR) ? alu_out : '0;

  assign rf_we       = done && dec.wr_rf;
  assign rf_wsel     = dec.sel;
  assign rf_wdata    = alu_out;
  assign flags_we    = done && dec.wr_flags;
  assign flags_wdata = alu_flags;
endmodule

// File: rtl/pfx_exec_chk.sv
module pfx_exec_chk #(
  parameter logic [7:0] PREFIX = 8'hCB
) (
  input logic        clk,
  input logic        rst,
  input logic        start,
  input logic [7:0]  first_op,
  input logic        busy,
  input logic        done,
  input logic        rf_we,
  input logic        flags_we,
  input logic [7:0]  flags_wdata,
  input logic        mem_valid,
  input logic        mem_ready,
  input logic        mem_we,
  input logic [15:0] mem_addr,
  input logic [7:0]  mem_wdata
);
  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R11
  rf_we_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    rf_we |-> done);

  // R11
  flags_we_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> done);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_we) && $stable(mem_wdata)));

  // R9
  flag_low_zero_chk: assert property (@(posedge clk) disable iff (rst)
    flags_we |-> (flags_wdata[3:0] == 4'h0));

  // R1
  non_prefix_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && start && first_op != PREFIX) |=> !busy);

  // R12
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_valid && !done));

  // R12
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!busy && !mem_valid));
endmodule

bind pfx_exec pfx_exec_chk #(.PREFIX(PREFIX)) i_chk (
  .clk        (clk),
  .rst        (rst),
  .start      (start),
  .first_op   (first_op),
  .busy       (busy),
  .done       (done),
  .rf_we      (rf_we),
  .flags_we   (flags_we),
  .flags_wdata(flags_wdata),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata)
);

// File: tb/test_pfx_exec.sv
module test_pfx_exec;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [7:0]  first_op = 8'h00;
  logic [15:0] pc_i = 16'h0000;
  logic        busy, done, rf_we, flags_we, mem_valid, mem_we, mem_ready;
  logic [15:0] pc_o, mem_addr;
  logic [63:0] rf_rd;
  logic [2:0]  rf_wsel;
  logic [7:0]  rf_wdata, flags_wdata, mem_wdata, mem_rdata;

  // bench-side models, owned by one process
  logic [7:0]  rf [8];
  logic [7:0]  flags;
  logic [7:0]  mem [256];
  int          stall;
  int          mem_wr_cnt, rf_wr_cnt, fl_wr_cnt;
  logic [15:0] last_waddr;

  // preload request
  logic        load = 1'b0;
  logic [7:0]  seed_rf [8];
  logic [7:0]  seed_flags, seed_op2, seed_opnd, seed_pc_lo, seed_l;
  int          seed_stall;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  pfx_exec i_pfx_exec (
    .clk(clk), .rst(rst), .start(start), .first_op(first_op), .pc_i(pc_i),
    .busy(busy), .done(done), .pc_o(pc_o), .rf_rd(rf_rd), .carry_i(flags[4]),
    .rf_we(rf_we), .rf_wsel(rf_wsel), .rf_wdata(rf_wdata),
    .flags_we(flags_we), .flags_wdata(flags_wdata),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always_comb for (int i = 0; i < 8; i++) rf_rd[i*8 +: 8] = rf[i];
  assign mem_ready = (stall == 0);
  assign mem_rdata = mem[mem_addr[7:0]];

  always @(posedge clk) begin
    if (load) begin
      for (int i = 0; i < 8; i++) rf[i] <= seed_rf[i];
      flags <= seed_flags;
      mem[seed_pc_lo] <= seed_op2;
      mem[seed_l] <= seed_opnd;
      stall <= seed_stall;
      mem_wr_cnt <= 0;
      rf_wr_cnt <= 0;
      fl_wr_cnt <= 0;
    end else begin
      if (mem_valid && stall != 0) stall <= stall - 1;
      if (mem_valid && mem_ready && mem_we) begin
        mem[mem_addr[7:0]] <= mem_wdata;
        last_waddr <= mem_addr;
        mem_wr_cnt <= mem_wr_cnt + 1;
      end
      if (rf_we) begin
        rf[rf_wsel] <= rf_wdata;
        rf_wr_cnt <= rf_wr_cnt + 1;
      end
      if (flags_we) begin
        flags <= flags_wdata;
        fl_wr_cnt <= fl_wr_cnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // reference behaviour worked out arithmetically from the requirements
  function automatic void ref_op(input int op, input int v, input int cin,
                                 output int r, output int f,
                                 output bit wr, output bit fw);
    int g, m, z, hh, cc;
    g = op / 64; m = (op / 8) % 8;
    hh = 0; cc = 0; r = v; wr = 1'b1; fw = 1'b1;
    case (g)
      0: case (m)
        0: begin r = (v * 2) % 256 + v / 128; cc = v / 128; end
        1: begin r = v / 2 + (v % 2) * 128;   cc = v % 2;   end
        2: begin r = (v * 2) % 256 + cin;     cc = v / 128; end
        3: begin r = v / 2 + cin * 128;       cc = v % 2;   end
        4: begin r = (v * 2) % 256;           cc = v / 128; end
        5: begin r = v / 2 + (v / 128) * 128; cc = v % 2;  end
        6: begin r = (v % 16) * 16 + v / 16;  cc = 0;       end
        default: begin r = v / 2;             cc = v % 2;   end
      endcase
      1: begin wr = 1'b0; hh = 1; cc = cin; end
      2: begin fw = 1'b0; if ((v >> m) % 2 == 1) r = v - (1 << m); end
      default: begin fw = 1'b0; if ((v >> m) % 2 == 0) r = v + (1 << m); end
    endcase
    if (g == 1) z = ((v >> m) % 2 == 0) ? 1 : 0;
    else z = (r == 0) ? 1 : 0;
    f = z * 128 + hh * 32 + cc * 16;
  endfunction

  function automatic string grp_req(input int op);
    case (op / 64)
      0: return "R4";
      1: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic run_op(input int op, input int pass, input int s, input bit poke);
    int sel, v, opv, cin, r, f, nexp, last, cyc;
    bit wr, fw;
    logic [7:0] erf [8];
    logic [7:0] eflags, emem;
    logic [15:0] pc;
    string gq;
    sel = op % 8;
    gq = grp_req(op);
    for (int k = 0; k < 8; k++) begin
      case (pass)
        2: seed_rf[k] = 8'h00;
        3: seed_rf[k] = 8'hFF;
        default: seed_rf[k] = 8'((op * 37 + k * 53 + pass * 91 + 5) % 256);
      endcase
    end
    case (pass)
      2: opv = 0;
      3: opv = 255;
      default: opv = (op * 11 + pass * 29 + 3) % 256;
    endcase
    cin = (op + pass) % 2;
    seed_flags = 8'h40 | 8'(cin << 4);
    seed_l = seed_rf[5];
    seed_pc_lo = seed_rf[5] ^ 8'h80;
    seed_op2 = 8'(op);
    seed_opnd = 8'(opv);
    seed_stall = s;
    pc = {8'(8'h21 + pass), seed_pc_lo};
    v = (sel == 6) ? opv : int'(seed_rf[sel]);
    ref_op(op, v, cin, r, f, wr, fw);
    for (int k = 0; k < 8; k++) erf[k] = seed_rf[k];
    if (wr && sel != 6) erf[sel] = 8'(r);
    emem = (wr && sel == 6) ? 8'(r) : 8'(opv);
    eflags = fw ? 8'(f) : seed_flags;
    nexp = (sel == 6) ? 16 : 8;
    last = 1 + s + ((sel == 6) ? 1 : 0) + ((sel == 6 && op / 64 != 1) ? 1 : 0);
    if (last + 1 > nexp) nexp = last + 1;

    load = 1'b1;
    @(posedge clk); #1;
    load = 1'b0;
    start = 1'b1; first_op = 8'hCB; pc_i = pc;
    @(posedge clk); #1;
    start = 1'b0;
    cyc = 1;
    while (!done && cyc < 100) begin
      if (poke && cyc == 3) begin start = 1'b1; pc_i = 16'hFFFF; end
      else start = 1'b0;
      @(posedge clk); #1;
      cyc++;
    end
    start = 1'b0;
    // R7 / R10 timing of the completion pulse
    chk(cyc == nexp, (s != 0) ? "R10" : "R7", "done cycle", cyc, nexp);
    // R2 counter advanced by one
    chk(pc_o == pc + 16'd1, "R2", "pc_o", pc_o, pc + 16'd1);
    @(posedge clk); #1;
    // R11 one-cycle pulse
    chk(!done, "R11", "done after pulse", done, 0);
    // R12 back to idle, and a start while busy was not taken
    chk(!busy, "R12", "busy after done", busy, 0);
    for (int k = 0; k < 8; k++)
      if (k != 6) chk(rf[k] == erf[k], (k == sel) ? gq : "R3", "register slot", rf[k], erf[k]);
    chk(flags == eflags, fw ? gq : "R6", "flags", flags, eflags);
    chk(flags[3:0] == 4'h0, "R9", "flag low nibble", flags, 0);
    chk(mem[seed_l] == emem, (sel == 6) ? "R8" : "R3", "memory operand", mem[seed_l], emem);
    chk(mem_wr_cnt == ((wr && sel == 6) ? 1 : 0), (op / 64 == 1) ? "R5" : "R8",
        "memory writes", mem_wr_cnt, (wr && sel == 6) ? 1 : 0);
    chk(rf_wr_cnt == ((wr && sel != 6) ? 1 : 0), (op / 64 == 1) ? "R5" : "R3",
        "register writes", rf_wr_cnt, (wr && sel != 6) ? 1 : 0);
    if (wr && sel == 6)
      chk(last_waddr == {seed_rf[4], seed_rf[5]}, "R8", "write address",
          last_waddr, {seed_rf[4], seed_rf[5]});
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) rf[i] = 8'h00;
    flags = 8'h00;
    stall = 0;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    // R12 reset state
    chk(!busy && !done && !mem_valid, "R12", "idle after reset",
        {busy, done, mem_valid}, 0);
    chk(pc_o == 16'h0000 && !rf_we && !flags_we, "R12", "outputs after reset",
        {pc_o, rf_we, flags_we}, 0);

    // R1 non-prefix opcodes are not taken
    foreach (seed_rf[i]) seed_rf[i] = 8'h00;
    for (int t = 0; t < 4; t++) begin
      start = 1'b1;
      first_op = (t == 0) ? 8'h00 : (t == 1) ? 8'hCA : (t == 2) ? 8'hCC : 8'h4B;
      pc_i = 16'h1234;
      @(posedge clk); #1;
      start = 1'b0;
      for (int c = 0; c < 5; c++) begin
        chk(!busy && !mem_valid && !done, "R1", "non-prefix start",
            {busy, mem_valid, done}, 0);
        @(posedge clk); #1;
      end
    end

    // exhaustive sweep of the second byte under four data patterns
    for (int p = 0; p < 4; p++)
      for (int o = 0; o < 256; o++) run_op(o, p, 0, 1'b0);

    // R10 stalls inside and beyond the budget
    run_op(8'h06, 0, 3, 1'b0);
    run_op(8'h06, 1, 20, 1'b0);
    run_op(8'h46, 0, 20, 1'b0);
    run_op(8'h37, 0, 20, 1'b0);
    run_op(8'h00, 1, 5, 1'b0);
    run_op(8'hFE, 0, 14, 1'b0);

    // R12 start while busy is ignored
    run_op(8'h11, 0, 0, 1'b1);
    run_op(8'h96, 1, 0, 1'b1);

    // R12 reset in the middle of a memory operation
    start = 1'b1; first_op = 8'hCB; pc_i = {8'h21, seed_pc_lo};
    @(posedge clk); #1;
    start = 1'b0;
    @(posedge clk); #1;
    rst = 1'b1;
    @(posedge clk); #1;
    rst = 1'b0;
    chk(!busy && !mem_valid && !done && pc_o == 16'h0000, "R12", "mid-op reset",
        {busy, mem_valid, done, pc_o}, 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL R7 watchdog: actual %0h expected %0h", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule